// File: doc/BRIEF.md
# Software-Refilled Translation Buffer

This block is a small set-associative translation buffer with no hardware walker. Entries are written only by privileged software. It has two arrays, one for instruction fetches and one for data accesses. The split can be turned off by a parameter, and fetches then share the data array. A lookup that finds no entry ends with a miss pulse and a cause code. The cause tells a fetch miss apart from a data-read miss and a data-write miss.

On a miss the block captures three things in registers that software can read. The first is the faulting address, with a proposed victim way folded into its two lowest bits. The second is a compare word carrying a valid flag. The third is a status word carrying the access key. The handler then writes the real page number into the low PTE register. It finishes by issuing a load command for the data array or for the instruction array, and that command writes the entry into the proposed way.

The proposed way rotates round-robin, starting from the way most recently loaded. Commands also cover removing one page and flushing everything.

Top module: `swtlb_top`

## Requirements
- R1: After reset every entry is invalid, all result and miss outputs are zero, and the first proposed way is 0.
- R2: A lookup accepted in one cycle reports on `res_valid_o` at the next clock edge. It hits only if the set holds a valid entry whose stored page tag equals the lookup address bits above the set index, and whose compare word equals {1, `lk_ptem_i`}. The set index is the address bits just above the 12-bit page offset. On a hit, `res_paddr_o` is PTE-low bits 31:12 joined to the address offset bits 11:0.
- R3: A miss pulses `miss_o` and sets `miss_cause_o`. `lk_kind_i` is 0 for a fetch, 1 for a load and 2 for a store. The cause is 1 for a fetch miss, 2 for a load miss and 3 for a store miss.
- R4: On a miss, the miss register becomes the address with bits 1:0 replaced by the proposed way, which is (last loaded way + 1) mod WAYS. The PTE-high register becomes {1, `lk_ptem_i`}.
- R5: On a miss, the status word holds the lookup key at bit 19 and zeros in every other bit.
- R6: `cmd_op_i` 0 loads the data array and 1 loads the instruction array. A load writes the set selected by `cmd_epn_i`, into the way given by the low bits of the miss register. It stores the page tag from `cmd_epn_i`, the compare word from PTE-high and the page word from PTE-low.
- R7: A load sets the last loaded way to the way just written, so the proposals rotate through all ways and wrap.
- R8: A load issued with `cmd_super_i` low pulses `priv_fault_o` one cycle later. It writes no entry and leaves the rotation unchanged.
- R9: `cmd_op_i` 2 invalidates, in the set selected by `cmd_epn_i`, every way whose tag matches. It does this in the data array, and in the instruction array as well when the arrays are split. Other entries stay valid.
- R10: `cmd_op_i` 3 invalidates every entry in both arrays.
- R11: A lookup that arrives in the same cycle as any command raises `lk_stall_o` and is not accepted. The requester repeats it later.
- R12: With `reg_we_i` high, software writes the register selected by `reg_sel_i`: 0 for the miss register, 1 for PTE-high, 2 for PTE-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_kind_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| lk_addr_i | input | 32 | Effective address |
| lk_ptem_i | input | 31 | Segment and page match fields |
| lk_key_i | input | 1 | Access key of the translation |
| lk_stall_o | output | 1 | Lookup refused this cycle |
| res_valid_o | output | 1 | Lookup result valid |
| res_hit_o | output | 1 | Lookup hit |
| res_paddr_o | output | 32 | Translated address |
| miss_o | output | 1 | Miss pulse |
| miss_cause_o | output | 2 | Cause of the last miss |
| miss_status_o | output | 32 | Status word with the key at bit 19 |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 2 | 0 load data, 1 load instruction, 2 invalidate page, 3 invalidate all |
| cmd_epn_i | input | 32 | Effective page operand |
| cmd_super_i | input | 1 | Supervisor mode |
| priv_fault_o | output | 1 | Privileged-command fault pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| tlbmiss_o | output | 32 | Miss register |
| ptehi_o | output | 32 | PTE-high (compare) register |
| ptelo_o | output | 32 | PTE-low (page) register |

## Verification
The hardest cases to reach are those that depend on the rotation history. Examples are the proposed way wrapping from 3 back to 0, and a refused user-mode load leaving that history untouched. Neither can be forced from outside. The stimulus table therefore runs a full software refill protocol, alternating misses with loads across both arrays, until four loads have moved the proposal once around all the ways. A further miss then shows the wrap. A user-mode load follows, and a second miss on the same page checks that the proposal did not advance.

// File: rtl/swtlb_pkg.sv
package swtlb_pkg;
  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;
  typedef enum logic [1:0] {CMD_LD_DATA = 2'd0, CMD_LD_INSN = 2'd1,
                            CMD_INV_ONE = 2'd2, CMD_INV_ALL = 2'd3} cmd_e;
  typedef enum logic [1:0] {CS_NONE = 2'd0, CS_ITLB = 2'd1,
                            CS_DLOAD = 2'd2, CS_DSTORE = 2'd3} cause_e;
  localparam logic [1:0] SEL_MISS = 2'd0;
  localparam logic [1:0] SEL_PTEHI = 2'd1;
  localparam logic [1:0] SEL_PTELO = 2'd2;
  localparam int KEY_BIT = 19;
endpackage

// File: rtl/swtlb_array.sv
module swtlb_array #(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 18,
  parameter int DAT_W = 32,
  localparam int SB = $clog2(SETS),
  localparam int WB = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SB-1:0]    lk_set_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  input  logic [DAT_W-1:0] lk_cmp_i,
  output logic             hit_o,
  output logic [DAT_W-1:0] rpn_o,
  input  logic             wr_en_i,
  input  logic [SB-1:0]    wr_set_i,
  input  logic [WB-1:0]    wr_way_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [DAT_W-1:0] wr_cmp_i,
  input  logic [DAT_W-1:0] wr_rpn_i,
  input  logic             inv_one_i,
  input  logic [SB-1:0]    inv_set_i,
  input  logic [TAG_W-1:0] inv_tag_i,
  input  logic             inv_all_i
);
  logic [SETS-1:0][WAYS-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [DAT_W-1:0] cmp_q [SETS][WAYS];
  logic [DAT_W-1:0] rpn_q [SETS][WAYS];

  // lowest matching way wins
  always_comb begin
    hit_o = 1'b0;
    rpn_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld_q[lk_set_i][w] && tag_q[lk_set_i][w] == lk_tag_i &&
          cmp_q[lk_set_i][w] == lk_cmp_i) begin
        hit_o = 1'b1;
        rpn_o = rpn_q[lk_set_i][w];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else if (inv_all_i) begin
      vld_q <= '0;
    end else begin
      if (inv_one_i) begin
        for (int w = 0; w < WAYS; w++)
          if (tag_q[inv_set_i][w] == inv_tag_i) vld_q[inv_set_i][w] <= 1'b0;
      end
      if (wr_en_i) vld_q[wr_set_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
      cmp_q[wr_set_i][wr_way_i] <= wr_cmp_i;
      rpn_q[wr_set_i][wr_way_i] <= wr_rpn_i;
    end
  end

  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_all_i |=> vld_q == '0);
  p_fill_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !inv_all_i) |=> vld_q[$past(wr_set_i)][$past(wr_way_i)]);
endmodule

// File: rtl/swtlb_miss_regs.sv
module swtlb_miss_regs
  import swtlb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAYS   = 4,
  localparam int WB = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic [ADDR_W-2:0] miss_ptem_i,
  input  logic              miss_key_i,
  input  logic              fill_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] tlbmiss_o,
  output logic [ADDR_W-1:0] ptehi_o,
  output logic [ADDR_W-1:0] ptelo_o,
  output logic [ADDR_W-1:0] status_o,
  output logic [WB-1:0]     fill_way_o
);
  logic [WB-1:0]     last_q;
  logic [WB-1:0]     sugg;
  logic [ADDR_W-1:0] tlbmiss_q, ptehi_q, ptelo_q, status_q;

  assign sugg       = last_q + 1'b1;  // WAYS is a power of two
  assign fill_way_o = tlbmiss_q[WB-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q    <= WB'(WAYS - 1);
      tlbmiss_q <= '0;
      ptehi_q   <= '0;
      ptelo_q   <= '0;
      status_q  <= '0;
    end else begin
      if (fill_i) last_q <= fill_way_o;
      if (miss_i) begin
        tlbmiss_q <= {miss_addr_i[ADDR_W-1:2], 2'(sugg)};
        ptehi_q   <= {1'b1, miss_ptem_i};
        status_q  <= ADDR_W'(miss_key_i) << KEY_BIT;
      end else if (reg_we_i) begin
        case (reg_sel_i)
          SEL_MISS:  tlbmiss_q <= reg_wdata_i;
          SEL_PTEHI: ptehi_q   <= reg_wdata_i;
          SEL_PTELO: ptelo_q   <= reg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign tlbmiss_o = tlbmiss_q;
  assign ptehi_o   = ptehi_q;
  assign ptelo_o   = ptelo_q;
  assign status_o  = status_q;

  p_way_moves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> tlbmiss_q[WB-1:0] != $past(last_q));
  p_cmp_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> ptehi_q[ADDR_W-1]);
  p_rotate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_i |=> $stable(last_q));
endmodule

// File: rtl/swtlb_top.sv
module swtlb_top
  import swtlb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter bit SPLIT     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [1:0]        lk_kind_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [ADDR_W-2:0] lk_ptem_i,
  input  logic              lk_key_i,
  output logic              lk_stall_o,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic [ADDR_W-1:0] res_paddr_o,
  output logic              miss_o,
  output logic [1:0]        miss_cause_o,
  output logic [ADDR_W-1:0] miss_status_o,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_epn_i,
  input  logic              cmd_super_i,
  output logic              priv_fault_o,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] tlbmiss_o,
  output logic [ADDR_W-1:0] ptehi_o,
  output logic [ADDR_W-1:0] ptelo_o
);
  localparam int SB    = $clog2(SETS);
  localparam int WB    = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - PAGE_BITS - SB;
  localparam int NARR  = SPLIT ? 2 : 1;

  logic [SB-1:0]     lk_set, cmd_set;
  logic [TAG_W-1:0]  lk_tag, cmd_tag;
  logic [ADDR_W-1:0] lk_cmp;
  logic              lk_arr, ld_arr, is_ld, ld_ok, inv_one, inv_all, go, hit;
  logic [1:0]        arr_hit;
  logic [ADDR_W-1:0] arr_rpn [2];
  logic [ADDR_W-1:0] rpn;
  logic [WB-1:0]     fill_way;
  cause_e            cause_d;
  logic              unused_bits;

  assign lk_set  = lk_addr_i[PAGE_BITS +: SB];
  assign lk_tag  = lk_addr_i[ADDR_W-1 -: TAG_W];
  assign lk_cmp  = {1'b1, lk_ptem_i};
  assign cmd_set = cmd_epn_i[PAGE_BITS +: SB];
  assign cmd_tag = cmd_epn_i[ADDR_W-1 -: TAG_W];

  assign lk_arr  = SPLIT && (lk_kind_i == ACC_FETCH);
  assign ld_arr  = SPLIT && (cmd_op_i == CMD_LD_INSN);
  assign is_ld   = cmd_valid_i && (cmd_op_i == CMD_LD_DATA || cmd_op_i == CMD_LD_INSN);
  assign ld_ok   = is_ld && cmd_super_i;
  assign inv_one = cmd_valid_i && (cmd_op_i == CMD_INV_ONE);
  assign inv_all = cmd_valid_i && (cmd_op_i == CMD_INV_ALL);

  // commands win; the lookup is refused and repeated by the requester
  assign go         = lk_valid_i && !cmd_valid_i;
  assign lk_stall_o = lk_valid_i && cmd_valid_i;

  logic [ADDR_W-1:0] ptehi_w, ptelo_w;

  for (genvar a = 0; a < NARR; a++) begin : g_arr
    swtlb_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DAT_W(ADDR_W)) u_arr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .lk_set_i  (lk_set),
      .lk_tag_i  (lk_tag),
      .lk_cmp_i  (lk_cmp),
      .hit_o     (arr_hit[a]),
      .rpn_o     (arr_rpn[a]),
      .wr_en_i   (ld_ok && (ld_arr == 1'(a))),
      .wr_set_i  (cmd_set),
      .wr_way_i  (fill_way),
      .wr_tag_i  (cmd_tag),
      .wr_cmp_i  (ptehi_w),
      .wr_rpn_i  (ptelo_w),
      .inv_one_i (inv_one),
      .inv_set_i (cmd_set),
      .inv_tag_i (cmd_tag),
      .inv_all_i (inv_all)
    );
  end
  if (NARR == 1) begin : g_shared
    assign arr_hit[1] = 1'b0;
    assign arr_rpn[1] = '0;
  end

  assign hit = arr_hit[lk_arr];
  assign rpn = arr_rpn[lk_arr];

  always_comb begin
    case (acc_e'(lk_kind_i))
      ACC_FETCH: cause_d = CS_ITLB;
      ACC_STORE: cause_d = CS_DSTORE;
      default:   cause_d = CS_DLOAD;
    endcase
  end

  swtlb_miss_regs #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .miss_i      (go && !hit),
    .miss_addr_i (lk_addr_i),
    .miss_ptem_i (lk_ptem_i),
    .miss_key_i  (lk_key_i),
    .fill_i      (ld_ok),
    .reg_we_i    (reg_we_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .tlbmiss_o   (tlbmiss_o),
    .ptehi_o     (ptehi_w),
    .ptelo_o     (ptelo_w),
    .status_o    (miss_status_o),
    .fill_way_o  (fill_way)
  );
  assign ptehi_o = ptehi_w;
  assign ptelo_o = ptelo_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o  <= 1'b0;
      res_hit_o    <= 1'b0;
      res_paddr_o  <= '0;
      miss_o       <= 1'b0;
      miss_cause_o <= CS_NONE;
      priv_fault_o <= 1'b0;
    end else begin
      res_valid_o  <= go;
      res_hit_o    <= go && hit;
      miss_o       <= go && !hit;
      priv_fault_o <= is_ld && !cmd_super_i;
      if (go && hit) res_paddr_o <= {rpn[ADDR_W-1:PAGE_BITS], lk_addr_i[PAGE_BITS-1:0]};
      if (go && !hit) miss_cause_o <= cause_d;
    end
  end

  assign unused_bits = ^{cmd_epn_i[PAGE_BITS-1:0], rpn[PAGE_BITS-1:0]};

  p_cmd_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> !res_valid_o);
  p_hit_xor_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_hit_o && miss_o));
  p_cause_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> miss_cause_o != CS_NONE);
  p_user_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ld && !cmd_super_i) |=> priv_fault_o);
endmodule

// File: tb/swtlb_top_tb.sv
module swtlb_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [1:0]  lk_kind = '0;
  logic [31:0] lk_addr = '0;
  logic [30:0] lk_ptem = '0;
  logic        lk_key = 1'b0;
  logic        lk_stall, res_valid, res_hit, miss, priv_fault;
  logic [31:0] res_paddr, miss_status, tlbmiss, ptehi, ptelo;
  logic [1:0]  miss_cause;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_epn = '0;
  logic        cmd_super = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  swtlb_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_valid_i(lk_valid), .lk_kind_i(lk_kind), .lk_addr_i(lk_addr),
    .lk_ptem_i(lk_ptem), .lk_key_i(lk_key), .lk_stall_o(lk_stall),
    .res_valid_o(res_valid), .res_hit_o(res_hit), .res_paddr_o(res_paddr),
    .miss_o(miss), .miss_cause_o(miss_cause), .miss_status_o(miss_status),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_epn_i(cmd_epn),
    .cmd_super_i(cmd_super), .priv_fault_o(priv_fault),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .tlbmiss_o(tlbmiss), .ptehi_o(ptehi), .ptelo_o(ptelo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [1:0] kind, input logic [31:0] addr,
                        input logic [30:0] ptem, input logic key);
    @(negedge clk);
    lk_valid = 1'b1; lk_kind = kind; lk_addr = addr; lk_ptem = ptem; lk_key = key;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic load(input logic [1:0] op, input logic [31:0] epn,
                      input logic [31:0] lo, input logic sup);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = lo;
    @(negedge clk);
    reg_we = 1'b0;
    cmd_valid = 1'b1; cmd_op = op; cmd_epn = epn; cmd_super = sup;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic command(input logic [1:0] op, input logic [31:0] epn);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_epn = epn; cmd_super = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // op: 0 lookup, 1 data load, 2 instruction load
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [30:0] ptem;
    logic [31:0] lo;
    logic        hit;
    logic [31:0] word;
    logic [1:0]  cause;
  } vec_t;

  localparam logic [31:0] A = 32'h0040_1237;
  localparam logic [31:0] Q = 32'h0040_2A10;
  localparam logic [30:0] P1 = 31'h0012_3456;
  localparam logic [30:0] P2 = 31'h0055_0001;

  localparam vec_t VECS [15] = '{
    '{2'd0, 2'd0, A, P1, 32'h0, 1'b0, 32'h0040_1234, 2'd1},
    '{2'd2, 2'd0, A, P1, 32'hABCD_E000, 1'b0, 32'h0, 2'd0},
    '{2'd0, 2'd0, A, P1, 32'h0, 1'b1, 32'hABCD_E237, 2'd0},
    '{2'd0, 2'd1, A, P1, 32'h0, 1'b0, 32'h0040_1235, 2'd2},
    '{2'd1, 2'd0, A, P1, 32'h1111_1000, 1'b0, 32'h0, 2'd0},
    '{2'd0, 2'd1, A, P1, 32'h0, 1'b1, 32'h1111_1237, 2'd0},
    '{2'd0, 2'd2, Q, P2, 32'h0, 1'b0, 32'h0040_2A12, 2'd3},
    '{2'd1, 2'd0, Q, P2, 32'h2222_2000, 1'b0, 32'h0, 2'd0},
    '{2'd0, 2'd2, Q, P2, 32'h0, 1'b1, 32'h2222_2A10, 2'd0},
    '{2'd0, 2'd1, A, P2, 32'h0, 1'b0, 32'h0040_1237, 2'd2},
    '{2'd0, 2'd0, Q, P2, 32'h0, 1'b0, 32'h0040_2A13, 2'd1},
    '{2'd2, 2'd0, Q, P2, 32'h3333_3000, 1'b0, 32'h0, 2'd0},
    '{2'd0, 2'd0, Q, P2, 32'h0, 1'b1, 32'h3333_3A10, 2'd0},
    '{2'd0, 2'd0, A, P1, 32'h0, 1'b1, 32'hABCD_E237, 2'd0},
    '{2'd0, 2'd1, 32'h0040_3000, P1, 32'h0, 1'b0, 32'h0040_3000, 2'd2}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", 32'(res_valid), 32'd0);
    chk("R1 miss", 32'(miss), 32'd0);
    chk("R1 tlbmiss", tlbmiss, 32'h0);
    chk("R1 ptehi", ptehi, 32'h0);

    // R2 R3 R4 R6 R7 table of refill protocol
    for (int i = 0; i < 15; i++) begin
      if (VECS[i].op == 2'd0) begin
        lookup(VECS[i].kind, VECS[i].addr, VECS[i].ptem, 1'b0);
        chk($sformatf("R2 valid v%0d", i), 32'(res_valid), 32'd1);
        chk($sformatf("R2 hit v%0d", i), 32'(res_hit), 32'(VECS[i].hit));
        if (VECS[i].hit) begin
          chk($sformatf("R6 paddr v%0d", i), res_paddr, VECS[i].word);
        end else begin
          chk($sformatf("R3 cause v%0d", i), 32'(miss_cause), 32'(VECS[i].cause));
          chk($sformatf("R4 R7 tlbmiss v%0d", i), tlbmiss, VECS[i].word);
          chk($sformatf("R4 ptehi v%0d", i), ptehi, {1'b1, VECS[i].ptem});
        end
      end else begin
        load(VECS[i].op - 2'd1, VECS[i].addr, VECS[i].lo, 1'b1);
      end
    end

    // R5 key bit
    lookup(2'd1, 32'h0040_5000, 31'h0007_7777, 1'b1);
    chk("R5 status key1", miss_status, 32'h0008_0000);
    chk("R7 wrap way0", tlbmiss, 32'h0040_5000);
    // R8 user-mode load refused
    load(2'd0, 32'h0040_5000, 32'h4444_4000, 1'b0);
    chk("R8 priv_fault", 32'(priv_fault), 32'd1);
    lookup(2'd1, 32'h0040_5000, 31'h0007_7777, 1'b0);
    chk("R8 no write", 32'(res_hit), 32'd0);
    chk("R8 rotation held", tlbmiss, 32'h0040_5000);
    chk("R5 status key0", miss_status, 32'h0);

    // R11 command beats lookup
    @(negedge clk);
    lk_valid = 1'b1; lk_kind = 2'd2; lk_addr = Q; lk_ptem = P2;
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_epn = 32'h00F0_0000; cmd_super = 1'b1;
    #1 chk("R11 stall", 32'(lk_stall), 32'd1);
    @(negedge clk);
    lk_valid = 1'b0; cmd_valid = 1'b0;
    chk("R11 no result", 32'(res_valid), 32'd0);

    // R9 invalidate one page in both arrays
    command(2'd2, A);
    lookup(2'd0, A, P1, 1'b0);
    chk("R9 insn entry gone", 32'(res_hit), 32'd0);
    lookup(2'd1, A, P1, 1'b0);
    chk("R9 data entry gone", 32'(res_hit), 32'd0);
    lookup(2'd2, Q, P2, 1'b0);
    chk("R9 other kept", res_paddr, 32'h2222_2A10);
    // R10 flush
    command(2'd3, 32'h0);
    lookup(2'd2, Q, P2, 1'b0);
    chk("R10 flushed data", 32'(res_hit), 32'd0);
    lookup(2'd0, Q, P2, 1'b0);
    chk("R10 flushed insn", 32'(res_hit), 32'd0);

    // R12 software register writes
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h8765_4321;
    @(negedge clk);
    reg_sel = 2'd0; reg_wdata = 32'h0040_9002;
    @(negedge clk);
    reg_we = 1'b0;
    chk("R12 ptehi write", ptehi, 32'h8765_4321);
    chk("R12 miss write", tlbmiss, 32'h0040_9002);

    summary();
  end
endmodule